// File: doc/BRIEF.md
# Block cache write-back engine

This block walks a contiguous range of memory, one cache line at a time, and asks a cache controller to write each line back, optionally dropping the line afterwards. Software sets a start address, then a length in words. The length write launches the walk, and the same register then reads back as a live progress figure that falls to zero when the last line request has been accepted by the cache. The walk proceeds while the processor keeps running. A configurable pause between line requests leaves most cache-port cycles to the processor.

Two channels share one walker. Each channel has its own address and length registers. One channel asks for write-back only. The other asks for write-back followed by invalidation. Only one walk runs at a time. A length write that arrives mid-walk is held on the bus until the running walk ends. A zero in the progress register means every request was handed over, not that the data has reached memory. A control bit, zero after reset, is passed along with each request to ask the memory side to track write completion.

Top module: `bcwb_engine`

## Requirements
- R1: Writing a nonzero length starts a walk whose first request address is the programmed address rounded down to a LINE_BYTES boundary. Every request address has its low log2(LINE_BYTES) bits at zero.
- R2: A walk issues ceil((w + N) / (LINE_BYTES/WORD_BYTES)) requests, where N is the length in words and w is the word index of the start address within its line. The requests go to ascending, consecutive line addresses.
- R3: Reading a channel's length register during its walk returns the remaining count. The count starts at the written value. It drops on each acknowledged request by the words that line covers: LINE_BYTES/WORD_BYTES minus w for the first line, a full line for later lines, never going below zero. It reads zero and `busy` is low once the last request is acknowledged.
- R4: Register selects: 0 = write-back base, 1 = write-back length, 2 = invalidate base, 3 = invalidate length, 4 = control (bit 0). Walks started through select 1 drive `cm_inv` low. Walks started through select 3 drive it high. The idle channel's length reads zero.
- R5: Writing a length of zero starts nothing. `busy` stays low and no request appears.
- R6: A length write (select 1 or 3) while `busy` is high sees `bus_ready` low until the walk ends, and is then accepted. Base and control writes, and all reads, never wait.
- R7: At most one request is outstanding. `cm_valid`, `cm_addr` and `cm_inv` hold steady until `cm_ack`.
- R8: Between an acknowledged request and the next request of the same walk, `cm_valid` is low for exactly REQ_GAP cycles.
- R9: Control bit 0 resets to 0 and reads back as written. Its value at the moment a walk starts is driven on `cm_track` for every request of that walk.
- R10: After synchronous reset, `busy` and `cm_valid` are low, and the length and control registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | DATA_W | Write data |
| bus_ready | output | 1 | Access accepted this cycle when high |
| bus_rdata | output | DATA_W | Read data, valid the cycle after an accepted read |
| cm_valid | output | 1 | Line maintenance request |
| cm_addr | output | ADDR_W | Line-aligned byte address |
| cm_inv | output | 1 | Invalidate the line after write-back |
| cm_track | output | 1 | Request completion tracking |
| cm_ack | input | 1 | Cache accepts the presented request |
| busy | output | 1 | A walk is in progress |

## Verification
The bench builds the engine with 16-byte lines of four 32-bit words, a 16-bit length field and one idle cycle between requests. Short lines make every start offset within a line cheap to reach, along with walks that cross several lines and 4 KB-style address boundaries. A gap of one makes the pacing window observable at every request. The cache model acknowledges with zero, one, two or twenty cycles of delay. The long delay keeps a walk open long enough to read intermediate progress and to collide a second length write with it.

// File: rtl/bcwb_pkg.sv
`timescale 1ns/1ps
package bcwb_pkg;
  // Register select codes; channel index is bit 1, base/length is bit 0.
  typedef enum logic [2:0] {
    SEL_WB_BASE = 3'd0,
    SEL_WB_CNT  = 3'd1,
    SEL_WI_BASE = 3'd2,
    SEL_WI_CNT  = 3'd3,
    SEL_CTRL    = 3'd4
  } sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_GAP  = 2'd2
  } wstate_e;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/bcwb_regs.sv
`timescale 1ns/1ps
module bcwb_regs
  import bcwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [2:0]        bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ready,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              live_inv,
  output logic              start,
  output logic [ADDR_W-1:0] start_base,
  output logic [CNT_W-1:0]  start_cnt,
  output logic              start_inv,
  output logic              track
);
  sel_e sel;
  logic is_cnt;
  logic wr_acc;
  logic rd_acc;
  logic [ADDR_W-1:0] base_q [NUM_CH];
  logic [CNT_W-1:0]  cnt_view [NUM_CH];

  assign sel       = sel_e'(bus_sel);
  assign is_cnt    = (sel == SEL_WB_CNT) || (sel == SEL_WI_CNT);
  // Length writes are held off while a walk is running.
  assign bus_ready = !(bus_valid && bus_write && is_cnt && busy);
  assign wr_acc    = bus_valid && bus_write && bus_ready;
  assign rd_acc    = bus_valid && !bus_write;

  assign start      = wr_acc && is_cnt && (bus_wdata[CNT_W-1:0] != '0);
  assign start_cnt  = bus_wdata[CNT_W-1:0];
  assign start_inv  = bus_sel[1];
  assign start_base = base_q[bus_sel[1]];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[ch] <= '0;
      end else if (wr_acc && (bus_sel == 3'(2 * ch))) begin
        base_q[ch] <= bus_wdata[ADDR_W-1:0];
      end
    end
    assign cnt_view[ch] = (busy && (live_inv == 1'(ch))) ? live_cnt : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      track <= 1'b0;
    end else if (wr_acc && (sel == SEL_CTRL)) begin
      track <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_acc) begin
      case (sel)
        SEL_WB_BASE: bus_rdata <= DATA_W'(base_q[0]);
        SEL_WB_CNT:  bus_rdata <= DATA_W'(cnt_view[0]);
        SEL_WI_BASE: bus_rdata <= DATA_W'(base_q[1]);
        SEL_WI_CNT:  bus_rdata <= DATA_W'(cnt_view[1]);
        SEL_CTRL:    bus_rdata <= DATA_W'(track);
        default:     bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/bcwb_pacer.sv
`timescale 1ns/1ps
module bcwb_pacer #(
  parameter int REQ_GAP = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic pace_go
);
  if (REQ_GAP == 0) begin : g_nogap
    logic unused_pacer;
    assign unused_pacer = &{1'b0, clk, rst};
    assign pace_go = kick;
  end else begin : g_gap
    localparam int GW = $clog2(REQ_GAP + 1);
    logic [GW-1:0] gcnt;
    always_ff @(posedge clk) begin
      if (rst) begin
        gcnt <= '0;
      end else if (kick) begin
        gcnt <= GW'(REQ_GAP);
      end else if (gcnt != '0) begin
        gcnt <= gcnt - 1'b1;
      end
    end
    assign pace_go = (gcnt == GW'(1));
  end
endmodule

// File: rtl/bcwb_walker.sv
`timescale 1ns/1ps
module bcwb_walker
  import bcwb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 20,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_base,
  input  logic [CNT_W-1:0]  start_cnt,
  input  logic              start_inv,
  input  logic              track,
  input  logic              cm_ack,
  input  logic              pace_go,
  output logic              kick,
  output logic              cm_valid,
  output logic [ADDR_W-1:0] cm_addr,
  output logic              cm_inv,
  output logic              cm_track,
  output logic              busy,
  output logic [CNT_W-1:0]  cnt_q
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int WB_W  = $clog2(WORD_BYTES);
  localparam int WPL   = LINE_BYTES / WORD_BYTES;
  localparam int LA_W  = ADDR_W - OFF_W;

  wstate_e          state;
  logic [LA_W-1:0]  line_q;
  logic [CNT_W-1:0] cover_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             ack_now;

  if (WB_W > 0) begin : g_lowbits
    logic unused_low;
    assign unused_low = ^start_base[WB_W-1:0];
  end

  assign ack_now = (state == ST_REQ) && cm_ack;
  assign cnt_nxt = (cnt_q > cover_q) ? (cnt_q - cover_q) : '0;
  assign kick    = ack_now && (cnt_nxt != '0);
  assign cm_addr = {line_q, {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      line_q   <= '0;
      cnt_q    <= '0;
      cover_q  <= '0;
      cm_valid <= 1'b0;
      cm_inv   <= 1'b0;
      cm_track <= 1'b0;
      busy     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_REQ;
            cm_valid <= 1'b1;
            busy     <= 1'b1;
            line_q   <= start_base[ADDR_W-1:OFF_W];
            cnt_q    <= start_cnt;
            cover_q  <= CNT_W'(WPL) - CNT_W'(start_base[OFF_W-1:WB_W]);
            cm_inv   <= start_inv;
            cm_track <= track;
          end
        end
        ST_REQ: begin
          if (cm_ack) begin
            cnt_q   <= cnt_nxt;
            cover_q <= CNT_W'(WPL);
            if (cnt_nxt == '0) begin
              state    <= ST_IDLE;
              cm_valid <= 1'b0;
              busy     <= 1'b0;
            end else begin
              line_q <= line_q + 1'b1;
              if (pace_go) begin
                cm_valid <= 1'b1;
              end else begin
                state    <= ST_GAP;
                cm_valid <= 1'b0;
              end
            end
          end
        end
        ST_GAP: begin
          if (pace_go) begin
            state    <= ST_REQ;
            cm_valid <= 1'b1;
          end
        end
        default: begin
          state    <= ST_IDLE;
          cm_valid <= 1'b0;
          busy     <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/bcwb_engine.sv
`timescale 1ns/1ps
module bcwb_engine #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 20,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 4,
  parameter int REQ_GAP    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [2:0]        bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ready,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cm_valid,
  output logic [ADDR_W-1:0] cm_addr,
  output logic              cm_inv,
  output logic              cm_track,
  input  logic              cm_ack,
  output logic              busy
);
  logic              start;
  logic [ADDR_W-1:0] start_base;
  logic [CNT_W-1:0]  start_cnt;
  logic              start_inv;
  logic              track;
  logic [CNT_W-1:0]  live_cnt;
  logic              kick;
  logic              pace_go;

  bcwb_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .busy(busy), .live_cnt(live_cnt), .live_inv(cm_inv),
    .start(start), .start_base(start_base), .start_cnt(start_cnt),
    .start_inv(start_inv), .track(track)
  );

  bcwb_pacer #(.REQ_GAP(REQ_GAP)) u_pacer (
    .clk(clk), .rst(rst), .kick(kick), .pace_go(pace_go)
  );

  bcwb_walker #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_walk (
    .clk(clk), .rst(rst),
    .start(start), .start_base(start_base), .start_cnt(start_cnt),
    .start_inv(start_inv), .track(track),
    .cm_ack(cm_ack), .pace_go(pace_go), .kick(kick),
    .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_inv(cm_inv),
    .cm_track(cm_track), .busy(busy), .cnt_q(live_cnt)
  );
endmodule

// File: rtl/bcwb_engine_chk.sv
`timescale 1ns/1ps
module bcwb_engine_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int REQ_GAP    = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [2:0]        bus_sel,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ready,
  input logic              cm_valid,
  input logic [ADDR_W-1:0] cm_addr,
  input logic              cm_inv,
  input logic              cm_ack,
  input logic              busy
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic              have_prev;
  logic [ADDR_W-1:0] prev_addr;
  logic              len_wr;

  assign len_wr = bus_valid && bus_write && ((bus_sel == 3'd1) || (bus_sel == 3'd3));

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (!busy) begin
      have_prev <= 1'b0;
    end else if (cm_valid && cm_ack) begin
      have_prev <= 1'b1;
      prev_addr <= cm_addr;
    end
  end

  a_r1_line_aligned: assert property (@(posedge clk) disable iff (rst)
    cm_valid |-> (cm_addr[OFF_W-1:0] == '0));

  a_r2_next_line: assert property (@(posedge clk) disable iff (rst)
    (cm_valid && have_prev) |-> (cm_addr == prev_addr + ADDR_W'(LINE_BYTES)));

  a_r3_req_within_busy: assert property (@(posedge clk) disable iff (rst)
    cm_valid |-> busy);

  a_r5_zero_len_idle: assert property (@(posedge clk) disable iff (rst)
    (len_wr && !busy && (bus_wdata == '0)) |=> !busy);

  a_r6_len_wait: assert property (@(posedge clk) disable iff (rst)
    (len_wr && busy) |-> !bus_ready);

  a_r7_hold_request: assert property (@(posedge clk) disable iff (rst)
    (cm_valid && !cm_ack) |=> (cm_valid && $stable(cm_addr) && $stable(cm_inv)));

  if (REQ_GAP > 0) begin : g_gap_chk
    a_r8_gap_after_ack: assert property (@(posedge clk) disable iff (rst)
      (cm_valid && cm_ack) |=> !cm_valid);
  end
endmodule

bind bcwb_engine bcwb_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES), .REQ_GAP(REQ_GAP)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
  .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_inv(cm_inv),
  .cm_ack(cm_ack), .busy(busy)
);

// File: tb/sim_bcwb_engine.sv
`timescale 1ns/1ps
module sim_bcwb_engine;
  localparam int AW = 32, DW = 32, CW = 16, LB = 16, WB = 4, GAP = 1;

  typedef struct packed {
    logic        inv;
    logic [31:0] base;
    logic [15:0] len;
    logic [7:0]  nlines;
    logic [31:0] first;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_1000, 16'd8,  8'd2, 32'h0000_1000},
    '{1'b0, 32'h0000_1004, 16'd4,  8'd2, 32'h0000_1000},
    '{1'b0, 32'h0000_200C, 16'd1,  8'd1, 32'h0000_2000},
    '{1'b0, 32'h0000_200C, 16'd2,  8'd2, 32'h0000_2000},
    '{1'b1, 32'h0000_3008, 16'd9,  8'd3, 32'h0000_3000},
    '{1'b1, 32'h0000_0040, 16'd1,  8'd1, 32'h0000_0040},
    '{1'b0, 32'h0000_0FF0, 16'd20, 8'd5, 32'h0000_0FF0},
    '{1'b1, 32'h0000_7FFC, 16'd5,  8'd2, 32'h0000_7FF0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0]    bus_sel = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_ready;
  logic [DW-1:0] bus_rdata;
  logic          cm_valid, cm_inv, cm_track, busy;
  logic [AW-1:0] cm_addr;
  logic          cm_ack = 1'b0;

  bcwb_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .LINE_BYTES(LB),
                .WORD_BYTES(WB), .REQ_GAP(GAP)) u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .cm_valid(cm_valid), .cm_addr(cm_addr),
    .cm_inv(cm_inv), .cm_track(cm_track), .cm_ack(cm_ack), .busy(busy)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;

  // Cache model: acknowledges after lat cycles, logs each request.
  int lat = 0, wcnt = 0, low_run = 0, gap_err = 0, hold_err = 0, nlog = 0;
  bit seen_ack = 0;
  logic [AW-1:0] held_addr;
  logic [AW-1:0] log_addr [64];
  logic          log_inv  [64];
  logic          log_trk  [64];

  always @(negedge clk) begin
    if (rst) begin
      cm_ack = 1'b0; wcnt = 0; low_run = 0; seen_ack = 0;
    end else if (cm_ack) begin
      cm_ack = 1'b0; wcnt = 0;
      low_run = cm_valid ? 0 : 1;
    end else if (cm_valid) begin
      if (wcnt == 0) begin
        held_addr = cm_addr;
        if (seen_ack && low_run != GAP) gap_err++;
      end else if (cm_addr != held_addr) hold_err++;
      if (wcnt >= lat) begin
        cm_ack = 1'b1; seen_ack = 1;
        if (nlog < 64) begin
          log_addr[nlog] = cm_addr; log_inv[nlog] = cm_inv; log_trk[nlog] = cm_track;
        end
        nlog++;
      end else wcnt++;
    end else begin
      low_run++;
      if (!busy) seen_ack = 0;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d, output int waited);
    @(negedge clk); #1;
    bus_valid = 1'b1; bus_write = 1'b1; bus_sel = s; bus_wdata = d; waited = 0;
    #1;
    while (!bus_ready && waited < 5000) begin
      @(negedge clk); #1; waited++;
    end
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk); #1;
    bus_valid = 1'b1; bus_write = 1'b0; bus_sel = s;
    @(posedge clk); #1;
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 5000) begin
      @(negedge clk); #1; t++;
    end
  endtask

  task automatic run_op(input logic inv, input logic [31:0] base, input logic [31:0] len);
    int w;
    wr(inv ? 3'd2 : 3'd0, base, w);
    wr(inv ? 3'd3 : 3'd1, len, w);
    wait_idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int s, w;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R10: reset state
    check(busy == 1'b0, "R10 busy", busy, 0);
    check(cm_valid == 1'b0, "R10 cm_valid", cm_valid, 0);
    rd(3'd1, d); check(d == 0, "R10 wb length", d, 0);
    rd(3'd3, d); check(d == 0, "R10 inv length", d, 0);
    rd(3'd4, d); check(d == 0, "R9 control reset", d, 0);

    // Table-driven walks (R1, R2, R3, R4, R9 with tracking off)
    for (int i = 0; i < NV; i++) begin
      lat = i % 3;
      s = nlog;
      run_op(VECS[i].inv, VECS[i].base, 32'(VECS[i].len));
      check(nlog - s == int'(VECS[i].nlines), "R2 line count", nlog - s, VECS[i].nlines);
      check(log_addr[s] == VECS[i].first, "R1 first line", log_addr[s], VECS[i].first);
      for (int j = 0; j < int'(VECS[i].nlines) && (s + j) < 64; j++) begin
        check(log_addr[s+j] == VECS[i].first + 32'(j * LB), "R2 line address",
              log_addr[s+j], VECS[i].first + 32'(j * LB));
        check(log_inv[s+j] == VECS[i].inv, "R4 invalidate flag", log_inv[s+j], VECS[i].inv);
        check(log_trk[s+j] == 1'b0, "R9 tracking off", log_trk[s+j], 0);
      end
      rd(VECS[i].inv ? 3'd3 : 3'd1, d);
      check(d == 0, "R3 length zero at end", d, 0);
      check(busy == 1'b0, "R3 busy low at end", busy, 0);
    end

    // R5: zero length starts nothing
    s = nlog;
    wr(3'd1, 32'd0, w);
    repeat (5) @(negedge clk);
    #1;
    check(busy == 1'b0, "R5 busy after zero", busy, 0);
    check(nlog == s, "R5 no request", nlog - s, 0);

    // R3 progress, R4 idle channel, R6 stalled length write
    lat = 20;
    s = nlog;
    wr(3'd0, 32'h1000, w);
    wr(3'd1, 32'd12, w);
    rd(3'd1, d); check(d == 12, "R3 initial progress", d, 12);
    rd(3'd3, d); check(d == 0, "R4 idle channel reads zero", d, 0);
    while (nlog == s) begin @(negedge clk); #1; end
    rd(3'd1, d); check(d == 8, "R3 progress after first line", d, 8);
    wr(3'd2, 32'h5000, w); check(w == 0, "R6 base write no wait", w, 0);
    wr(3'd3, 32'd4, w);    check(w > 0, "R6 length write waited", w, 1);
    wait_idle();
    check(nlog - s == 4, "R6 both walks ran", nlog - s, 4);
    check(log_addr[s+2] == 32'h1020, "R2 last line of first walk", log_addr[s+2], 32'h1020);
    check(log_addr[s+3] == 32'h5000, "R6 queued walk after", log_addr[s+3], 32'h5000);
    check(log_inv[s+3] == 1'b1, "R4 queued walk invalidates", log_inv[s+3], 1);
    lat = 0;

    // R9: tracking bit
    wr(3'd4, 32'd1, w);
    rd(3'd4, d); check(d == 1, "R9 control readback", d, 1);
    s = nlog;
    run_op(1'b0, 32'h6004, 32'd6);
    check(nlog - s == 2, "R2 tracked walk lines", nlog - s, 2);
    check(log_trk[s] == 1'b1 && log_trk[s+1] == 1'b1, "R9 tracking on",
          {log_trk[s], log_trk[s+1]}, 2'b11);
    wr(3'd4, 32'd0, w);

    // R7 / R8 observed by the cache model across all walks
    check(hold_err == 0, "R7 request held", hold_err, 0);
    check(gap_err == 0, "R8 request gap", gap_err, 0);

    finish_run();
  end
endmodule